// File: doc/BRIEF.md
# Watchdog Timer with Seconds/Minutes Unit Select

This block guards against software lockups. Firmware writes a byte-wide timeout value through a small register bus; any nonzero value arms the timer and loads that many time units, and repeating the write restarts the countdown. Writing zero turns the watchdog off. If the countdown reaches its end without a fresh write, the block raises a reset request pulse of fixed length and then returns to the disabled state.

A second register holds a unit-select bit (bit 7). When that bit is set the timeout is counted in seconds, and when it is clear the timeout is counted in minutes. This gives a range from 1 second up to 255 minutes. An internal prescaler derives the one-second tick from the clock frequency parameter, and it derives the one-minute tick by counting sixty seconds. Every load of the timeout register clears the prescaler, so the first unit after a service is always a whole unit.

Top module: `watchdog_timer`

## Requirements
- R1: Reset state. After reset, both registers read 00h, the watchdog is disabled and `wdt_rst_o` is low.
- R2: A write of a nonzero value N to the timeout register (bus_addr = 1) arms the watchdog. With seconds selected, `wdt_rst_o` rises on exactly the N*CLK_HZ-th clock edge after the write edge, and it stays low before that edge.
- R3: A write of 00h to the timeout register disables the watchdog. No reset pulse follows until a nonzero value is written again.
- R4: Rewriting the timeout register while the timer is armed restarts the countdown from the new value, counted from the rewrite edge. The prescaler is cleared, so no partial unit carries over.
- R5: Bit 7 of the control register (bus_addr = 0) selects the unit. A value of 1 selects seconds (CLK_HZ clocks per unit) and a value of 0 selects minutes (60*CLK_HZ clocks per unit). The other control bits do not affect timing.
- R6: On expiry, `wdt_rst_o` is high for exactly PULSE_CLKS clocks. The watchdog is then disabled, and it gives no further pulse without a new nonzero write.
- R7: A read returns the last value written to the addressed register (bus_addr 0 for control, 1 for timeout), including after an expiry.
- R8: A bus cycle with `bus_sel` low, or with `bus_we` low, changes no register and does not arm or service the timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write enable, qualified by bus_sel |
| bus_addr | input | 1 | 0 = control, 1 = timeout |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| wdt_rst_o | output | 1 | Reset request pulse, PULSE_CLKS clocks long |

## Verification
The assertions assume that the bus inputs are sampled only on rising edges and that `bus_sel` is held low while reset is applied. The bench drives every input on the falling edge and keeps the select low during reset. The bench also shortens CLK_HZ to ten clocks, so that minute-scale timeouts stay within a short run. Each expiry is checked one cycle before the predicted edge and on that edge, which pins the countdown to the exact clock.

// File: rtl/wdt_pkg.sv
// Package: shared constants and register selector for the watchdog.
// Assumes an 8-bit data path and two registers decoded by one address bit.
package wdt_pkg;
    localparam int DATA_W   = 8;
    localparam int UNIT_BIT = 7;

    typedef enum logic [0:0] {
        SEL_CTRL    = 1'b0,
        SEL_TIMEOUT = 1'b1
    } wdt_reg_e;
endpackage

// File: rtl/wdt_regs.sv
// Module: host register file for the watchdog.
// Holds the control and timeout bytes and returns them on reads.
// A qualified write to the timeout register emits a one-cycle load strobe.
// Assumes single-cycle writes, qualified by bus_sel and bus_we together.
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              load,
    output logic [DATA_W-1:0] load_val
);
    logic [DATA_W-1:0] tmo_q;
    logic              wr;

    // Purpose: qualify bus writes and produce the load strobe.
    always_comb begin
        wr       = bus_sel && bus_we;
        load     = wr && (wdt_reg_e'(bus_addr) == SEL_TIMEOUT);
        load_val = bus_wdata;
    end

    // Purpose: capture written bytes into the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            tmo_q  <= '0;
        end else if (wr) begin
            if (wdt_reg_e'(bus_addr) == SEL_CTRL) ctrl_q <= bus_wdata;
            else                                  tmo_q  <= bus_wdata;
        end
    end

    // Purpose: read multiplexer returning the last written value.
    always_comb begin
        bus_rdata = (wdt_reg_e'(bus_addr) == SEL_CTRL) ? ctrl_q : tmo_q;
    end

    assert_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) |-> tmo_q == $past(bus_wdata));
    assert_unselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_sel) |-> ($stable(tmo_q) && $stable(ctrl_q)));
endmodule

// File: rtl/wdt_prescaler.sv
// Module: time-base prescaler.
// Produces a one-cycle tick every CLK_HZ clocks (one second). It also produces
// a one-cycle tick on every SEC_PER_MIN-th second tick (one minute).
// Assumes CLK_HZ >= 1 and SEC_PER_MIN >= 2. It counts only while run is high,
// and clr restarts both stages from zero.
module wdt_prescaler #(
    parameter int CLK_HZ      = 50_000_000,
    parameter int SEC_PER_MIN = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic sec_tick,
    output logic min_tick
);
    localparam int SEC_W = $clog2(CLK_HZ + 1);
    localparam int MIN_W = $clog2(SEC_PER_MIN);
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(CLK_HZ - 1);
    localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(SEC_PER_MIN - 1);

    logic [SEC_W-1:0] sec_cnt;
    logic [MIN_W-1:0] min_cnt;

    // Purpose: decode the terminal counts into ticks.
    always_comb begin
        sec_tick = run && (sec_cnt == SEC_LAST);
        min_tick = sec_tick && (min_cnt == MIN_LAST);
    end

    // Purpose: clock-to-second divider.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || clr) sec_cnt <= '0;
        else if (sec_tick)         sec_cnt <= '0;
        else                       sec_cnt <= sec_cnt + 1'b1;
    end

    // Purpose: second-to-minute divider.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || clr) min_cnt <= '0;
        else if (min_tick)         min_cnt <= '0;
        else if (sec_tick)         min_cnt <= min_cnt + 1'b1;
    end

    assert_clear_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sec_cnt == '0 && min_cnt == '0));
    assert_idle_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> (sec_cnt == '0));
endmodule

// File: rtl/wdt_countdown.sv
// Module: timeout counter and reset pulse generator.
// A load with a nonzero value arms the timer, and a load with zero disarms it.
// Each unit tick decrements the count. When the count runs out, the timer
// disarms and drives rst_o for PULSE_CLKS clocks.
// Assumes the unit tick is a one-cycle strobe. A load takes priority over a
// tick in the same cycle.
module wdt_countdown
    import wdt_pkg::*;
#(
    parameter int PULSE_CLKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              unit_tick,
    output logic              armed,
    output logic              rst_o
);
    localparam int PW = $clog2(PULSE_CLKS + 1);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W-1:0] count;
    logic [PW-1:0]     pulse_cnt;
    logic              expire;

    // Purpose: detect the final unit of an armed countdown.
    always_comb begin
        expire = armed && unit_tick && !load && (count == ONE);
        rst_o  = (pulse_cnt != '0);
    end

    // Purpose: arm, service, disarm and decrement the timeout count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            count <= '0;
        end else if (load) begin
            armed <= (load_val != '0);
            count <= load_val;
        end else if (expire) begin
            armed <= 1'b0;
            count <= '0;
        end else if (armed && unit_tick) begin
            count <= count - ONE;
        end
    end

    // Purpose: stretch an expiry into a fixed-length reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)               pulse_cnt <= '0;
        else if (expire)          pulse_cnt <= PW'(PULSE_CLKS);
        else if (pulse_cnt != '0) pulse_cnt <= pulse_cnt - 1'b1;
    end

    assert_armed_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (count != '0));
    assert_pulse_from_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_o) |-> $past(armed));
    assert_disarm_on_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_o) |-> !armed);
    assert_zero_disarms_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val == '0) |=> !armed);
endmodule

// File: rtl/watchdog_timer.sv
// Module: top of the software-serviced watchdog timer.
// It connects the register file, the prescaler and the countdown. Control
// bit 7 selects seconds (1) or minutes (0) as the countdown unit.
// Assumes clk runs at CLK_HZ and rst_n is synchronous.
module watchdog_timer #(
    parameter int CLK_HZ      = 50_000_000,
    parameter int SEC_PER_MIN = 60,
    parameter int PULSE_CLKS  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sel,
    input  logic       bus_we,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       wdt_rst_o
);
    import wdt_pkg::*;

    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] load_val;
    logic              load;
    logic              armed;
    logic              sec_tick;
    logic              min_tick;
    logic              unit_tick;

    wdt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ctrl_q    (ctrl_q),
        .load      (load),
        .load_val  (load_val)
    );

    wdt_prescaler #(
        .CLK_HZ      (CLK_HZ),
        .SEC_PER_MIN (SEC_PER_MIN)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (armed),
        .clr      (load),
        .sec_tick (sec_tick),
        .min_tick (min_tick)
    );

    // Purpose: pick the countdown unit from the control register.
    always_comb begin
        unit_tick = ctrl_q[UNIT_BIT] ? sec_tick : min_tick;
    end

    wdt_countdown #(
        .PULSE_CLKS (PULSE_CLKS)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_val  (load_val),
        .unit_tick (unit_tick),
        .armed     (armed),
        .rst_o     (wdt_rst_o)
    );
endmodule

// File: tb/tb_watchdog_timer.sv
module tb_watchdog_timer;
    localparam int HZ    = 10;
    localparam int SPM   = 60;
    localparam int PULSE = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       wdt_rst_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    watchdog_timer #(.CLK_HZ(HZ), .SEC_PER_MIN(SPM), .PULSE_CLKS(PULSE)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_rst_o(wdt_rst_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 60000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired: actual=%0d expected<=60000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_wr(input logic a, input logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic read_chk(input logic a, input logic [7:0] exp, input string req);
        bus_addr = a;
        #1;
        check(bus_rdata == exp, req, bus_rdata, exp);
    endtask

    // Called at the negedge right after the write edge; expiry due T edges later.
    task automatic expect_expiry(input int t, input string req);
        wait_n(t - 1);
        check(wdt_rst_o == 1'b0, {req, " early"}, wdt_rst_o, 0);
        wait_n(1);
        check(wdt_rst_o == 1'b1, {req, " on time"}, wdt_rst_o, 1);
        for (int i = 1; i < PULSE; i++) begin
            wait_n(1);
            check(wdt_rst_o == 1'b1, "R6 pulse width", wdt_rst_o, 1);
        end
        wait_n(1);
        check(wdt_rst_o == 1'b0, "R6 pulse end", wdt_rst_o, 0);
    endtask

    task automatic stays_low(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wdt_rst_o) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    task automatic t_reset;
        read_chk(1'b0, 8'h00, "R1 ctrl reset");
        read_chk(1'b1, 8'h00, "R1 timeout reset");
        check(wdt_rst_o == 1'b0, "R1 rst low", wdt_rst_o, 0);
        stays_low(50, "R1 disabled after reset");
    endtask

    task automatic t_seconds;
        bus_wr(1'b0, 8'h80);
        bus_wr(1'b1, 8'h03);
        expect_expiry(3 * HZ, "R2 seconds expiry");
        stays_low(100, "R6 disabled after pulse");
        read_chk(1'b1, 8'h03, "R7 timeout after expiry");
        read_chk(1'b0, 8'h80, "R7 ctrl readback");
    endtask

    task automatic t_disable;
        bus_wr(1'b1, 8'h05);
        wait_n(20);
        bus_wr(1'b1, 8'h00);
        stays_low(200, "R3 zero disables");
        read_chk(1'b1, 8'h00, "R7 zero readback");
    endtask

    task automatic t_service;
        bus_wr(1'b1, 8'h02);
        wait_n(14);
        bus_wr(1'b1, 8'h02);
        expect_expiry(2 * HZ, "R4 service restarts");
        bus_wr(1'b1, 8'h1E);
        expect_expiry(30 * HZ, "R2 30 seconds");
    endtask

    task automatic t_minutes;
        bus_wr(1'b0, 8'h7F);
        read_chk(1'b0, 8'h7F, "R7 ctrl other bits");
        bus_wr(1'b1, 8'h02);
        expect_expiry(2 * SPM * HZ, "R5 minutes unit");
        bus_wr(1'b0, 8'h00);
        bus_wr(1'b1, 8'h01);
        expect_expiry(SPM * HZ, "R5 one minute");
    endtask

    task automatic t_ignored;
        bus_wr(1'b0, 8'h80);
        bus_sel = 1'b0; bus_we = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h01;
        @(negedge clk);
        bus_we = 1'b0;
        read_chk(1'b1, 8'h01, "R8 sel low no write");
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 1'b0; bus_wdata = 8'h00;
        @(negedge clk);
        bus_sel = 1'b0;
        read_chk(1'b0, 8'h80, "R8 we low no write");
        stays_low(40, "R8 no arming");
    endtask

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_seconds();
        t_disable();
        t_service();
        t_minutes();
        t_ignored();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule